// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns an effective address into a real address by reading a radix translation tree out of memory. A walk is started with the effective address, a process ID, a partition ID, the hypervisor-state flag, the partition's radix flag and the base and size code of the process table. The walker checks the partition settings and the process table bounds first. It then reads the process-table entry, which gives the root directory base, the root index width and the total translated width. After that it descends one directory level per memory read until a leaf entry ends the walk.

Every directory entry names the base and the index width of the next level, so each level may consume a different number of address bits. A leaf can appear at any level, which gives large pages. The result is the real address, the page size as a bit count, the leaf entry and the address it was read from. A failed walk instead returns a fault with a one-hot cause. Permission evaluation and caching of results are done by other blocks.

Memory is reached through a 64-bit read port with a valid/ready request and a separate response strobe. At most one read is in flight.

Top module: `radix_walker`

## Requirements
- R1: A start with the partition radix flag clear, or with partition ID 0 while the hypervisor flag is clear, finishes with a fault of cause bad-configuration and issues no memory read.
- R2: The process table spans 2^(size code + 12) bytes and each of its entries is 16 bytes. A process ID whose byte offset (ID × 16) is at or past that span faults with cause no-entry and issues no read. Otherwise the first read is at table base + ID × 16.
- R3: In the process-table entry, bits [55:8] (with eight zero bits appended) are the root directory base, bits [4:0] are the root index width and bits [61:56] are the total translated width in bits.
- R4: Before each directory read, an index width below 5, or an index width larger than the bits still untranslated, faults with cause bad-configuration.
- R5: The index at a level is the effective address shifted right by (untranslated bits − index width) and masked to the index width. The entry is read from base + 8 × index, and the untranslated count then drops by the index width.
- R6: A directory entry with bit 63 (valid) clear faults with cause no-entry.
- R7: A valid entry with bit 62 (leaf) set ends the walk. With p the untranslated count, the real address is entry bits [55:12] (shifted to their place) with bits below p cleared, OR the effective-address bits below p. The page size output is p, and the leaf entry and its read address are returned.
- R8: A valid non-leaf entry supplies the next base from bits [55:8] and the next index width from bits [4:0].
- R9: At most MAX_LEVELS directory reads follow the process-table read. A non-leaf entry at the last allowed level faults with cause bad-configuration.
- R10: A read request keeps its valid and address stable until accepted, and no new request is raised until the response to the previous one arrives.
- R11: `done` pulses for one cycle at the end of each walk. `busy` is high from the cycle after an accepted start through the `done` cycle. A start while busy is ignored. Results hold until the next start. Reset leaves the block idle with no request.
- R12: Fault cause encoding: bit 0 no-entry, bit 1 bad-configuration. Exactly one bit is set on a fault, and the cause is 0 on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| ea | input | 64 | Effective address to translate |
| pid | input | PID_W | Process ID indexing the process table |
| lpid | input | LPID_W | Partition ID |
| hyp_mode | input | 1 | Requester runs in hypervisor state |
| part_radix | input | 1 | Partition entry marks radix translation |
| ptab_base | input | 64 | Process table base address |
| ptab_size | input | 5 | Process table size code |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk strobe |
| fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 2 | Bit 0 no-entry, bit 1 bad-configuration |
| real_addr | output | 64 | Translated real address |
| page_size | output | 7 | Page size as log2 of bytes |
| leaf_entry | output | 64 | Leaf entry contents |
| leaf_addr | output | 64 | Address the leaf was read from |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 64 | Read request address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Read data |

## Verification
Walks are run over trees of several shapes: four levels down to small pages, a leaf at the middle level, a leaf directly under the root, and a chain of minimum-width levels that exceeds the depth limit. These shapes separate correct per-level shift arithmetic from a fixed index width and show whether the large-page mask and the level counter are applied at the right point. Fault patterns cover an invalid entry part way down, a too-narrow index at the root and at a lower level, and an index wider than the remaining bits. The partition flag and partition ID 0 cases, process IDs on both sides of the table boundary, and two table size codes test the checks made before any read. A start pulse in the middle of a walk, together with irregular ready and response timing, checks that the walk in progress keeps its captured inputs and that the handshake rules hold.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

    localparam int WORD_W   = 64;
    localparam int VALID_B  = 63;
    localparam int LEAF_B   = 62;
    localparam int ADDR_HI  = 55;
    localparam int BASE_LO  = 8;
    localparam int PAGE_LO  = 12;
    localparam int NLS_W    = 5;
    localparam int TSIZE_LO = 56;
    localparam int TSIZE_W  = 6;
    localparam int MIN_NLS  = 5;
    localparam int PRTE_LG2 = 4;   // 16-byte process-table entries
    localparam int DIRE_LG2 = 3;   // 8-byte directory entries
    localparam int PTAB_MIN = 12;  // smallest table is 4 KiB

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_CHECK,
        WK_REQ,
        WK_WAIT,
        WK_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_NOENT  = 2'b01,
        CAUSE_BADCFG = 2'b10
    } cause_e;

endpackage

// File: rtl/rw_prtab_check.sv
module rw_prtab_check
    import radix_walk_pkg::*;
#(
    parameter int PID_W  = 20,
    parameter int LPID_W = 12
) (
    input  logic [PID_W-1:0]  pid,
    input  logic [LPID_W-1:0] lpid,
    input  logic              hyp,
    input  logic              radix_ok,
    input  logic [WORD_W-1:0] tbl_base,
    input  logic [4:0]        tbl_size,
    output logic [WORD_W-1:0] entry_addr,
    output logic              bad_cfg,
    output logic              no_entry
);

    logic [WORD_W-1:0] offset;
    logic [WORD_W-1:0] span;
    logic [5:0]        span_lg2;

    always_comb begin
        offset     = WORD_W'(pid) << PRTE_LG2;
        span_lg2   = {1'b0, tbl_size} + 6'(PTAB_MIN);
        span       = {{(WORD_W-1){1'b0}}, 1'b1} << span_lg2;
        no_entry   = (offset >= span);
        bad_cfg    = !radix_ok || ((lpid == '0) && !hyp);
        entry_addr = tbl_base + offset;
    end

endmodule

// File: rtl/rw_level_index.sv
module rw_level_index
    import radix_walk_pkg::*;
(
    input  logic [WORD_W-1:0] ea,
    input  logic [WORD_W-1:0] base,
    input  logic [NLS_W-1:0]  nls,
    input  logic [6:0]        rem,
    output logic [WORD_W-1:0] entry_addr,
    output logic [6:0]        rem_next,
    output logic              cfg_bad
);

    logic [WORD_W-1:0] idx_mask;
    logic [WORD_W-1:0] idx;

    always_comb begin
        cfg_bad    = (nls < NLS_W'(MIN_NLS)) || ({2'b00, nls} > rem);
        rem_next   = rem - {2'b00, nls};
        idx_mask   = ({{(WORD_W-1){1'b0}}, 1'b1} << nls) - 1'b1;
        idx        = (ea >> rem_next[5:0]) & idx_mask;
        entry_addr = base + (idx << DIRE_LG2);
    end

endmodule

// File: rtl/rw_leaf_form.sv
module rw_leaf_form
    import radix_walk_pkg::*;
(
    input  logic [WORD_W-1:0] entry,
    input  logic [WORD_W-1:0] ea,
    input  logic [5:0]        rem,
    output logic [WORD_W-1:0] real_addr
);

    logic [WORD_W-1:0] off_mask;
    logic [WORD_W-1:0] page_num;

    always_comb begin
        off_mask  = ({{(WORD_W-1){1'b0}}, 1'b1} << rem) - 1'b1;
        page_num  = {{(WORD_W-ADDR_HI-1){1'b0}}, entry[ADDR_HI:PAGE_LO], {PAGE_LO{1'b0}}};
        real_addr = (page_num & ~off_mask) | (ea & off_mask);
    end

endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import radix_walk_pkg::*;
#(
    parameter int PID_W      = 20,
    parameter int LPID_W     = 12,
    parameter int MAX_LEVELS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [63:0]       ea,
    input  logic [PID_W-1:0]  pid,
    input  logic [LPID_W-1:0] lpid,
    input  logic              hyp_mode,
    input  logic              part_radix,
    input  logic [63:0]       ptab_base,
    input  logic [4:0]        ptab_size,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_cause,
    output logic [63:0]       real_addr,
    output logic [6:0]        page_size,
    output logic [63:0]       leaf_entry,
    output logic [63:0]       leaf_addr,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [63:0]       mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);

    localparam int LVL_W = $clog2(MAX_LEVELS + 1);

    typedef struct packed {
        walk_st_e          st;
        logic              is_root;
        logic [WORD_W-1:0] ea;
        logic [WORD_W-1:0] base;
        logic [NLS_W-1:0]  nls;
        logic [6:0]        rem;
        logic [LVL_W-1:0]  lvl;
        logic [WORD_W-1:0] addr;
        logic              fault;
        cause_e            cause;
        logic [WORD_W-1:0] ra;
        logic [6:0]        psize;
        logic [WORD_W-1:0] leaf;
        logic [WORD_W-1:0] leaf_addr;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [WORD_W-1:0] pt_addr;
    logic              pt_bad, pt_noent;
    logic [WORD_W-1:0] lvl_addr;
    logic [6:0]        lvl_rem_next;
    logic              lvl_bad;
    logic [WORD_W-1:0] leaf_ra;
    logic [WORD_W-1:0] ent_base;
    logic [NLS_W-1:0]  ent_nls;

    rw_prtab_check #(
        .PID_W  (PID_W),
        .LPID_W (LPID_W)
    ) u_prtab (
        .pid        (pid),
        .lpid       (lpid),
        .hyp        (hyp_mode),
        .radix_ok   (part_radix),
        .tbl_base   (ptab_base),
        .tbl_size   (ptab_size),
        .entry_addr (pt_addr),
        .bad_cfg    (pt_bad),
        .no_entry   (pt_noent)
    );

    rw_level_index u_index (
        .ea         (r_q.ea),
        .base       (r_q.base),
        .nls        (r_q.nls),
        .rem        (r_q.rem),
        .entry_addr (lvl_addr),
        .rem_next   (lvl_rem_next),
        .cfg_bad    (lvl_bad)
    );

    rw_leaf_form u_leaf (
        .entry     (mem_rsp_data),
        .ea        (r_q.ea),
        .rem       (r_q.rem[5:0]),
        .real_addr (leaf_ra)
    );

    assign ent_base = {{(WORD_W-ADDR_HI-1){1'b0}}, mem_rsp_data[ADDR_HI:BASE_LO], {BASE_LO{1'b0}}};
    assign ent_nls  = mem_rsp_data[NLS_W-1:0];

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            WK_IDLE: begin
                if (start) begin
                    r_d.ea        = ea;
                    r_d.fault     = 1'b0;
                    r_d.cause     = CAUSE_NONE;
                    r_d.ra        = '0;
                    r_d.psize     = '0;
                    r_d.leaf      = '0;
                    r_d.leaf_addr = '0;
                    r_d.lvl       = '0;
                    r_d.is_root   = 1'b1;
                    if (pt_bad) begin
                        r_d.fault = 1'b1;
                        r_d.cause = CAUSE_BADCFG;
                        r_d.st    = WK_DONE;
                    end else if (pt_noent) begin
                        r_d.fault = 1'b1;
                        r_d.cause = CAUSE_NOENT;
                        r_d.st    = WK_DONE;
                    end else begin
                        r_d.addr = pt_addr;
                        r_d.st   = WK_REQ;
                    end
                end
            end
            WK_REQ: begin
                if (mem_rd_ready) begin
                    r_d.st = WK_WAIT;
                end
            end
            WK_WAIT: begin
                if (mem_rsp_valid) begin
                    if (r_q.is_root) begin
                        r_d.is_root = 1'b0;
                        r_d.base    = ent_base;
                        r_d.nls     = ent_nls;
                        r_d.rem     = {1'b0, mem_rsp_data[TSIZE_LO +: TSIZE_W]};
                        r_d.st      = WK_CHECK;
                    end else if (!mem_rsp_data[VALID_B]) begin
                        r_d.fault = 1'b1;
                        r_d.cause = CAUSE_NOENT;
                        r_d.st    = WK_DONE;
                    end else if (mem_rsp_data[LEAF_B]) begin
                        r_d.ra        = leaf_ra;
                        r_d.psize     = r_q.rem;
                        r_d.leaf      = mem_rsp_data;
                        r_d.leaf_addr = r_q.addr;
                        r_d.st        = WK_DONE;
                    end else begin
                        r_d.base = ent_base;
                        r_d.nls  = ent_nls;
                        r_d.lvl  = r_q.lvl + 1'b1;
                        r_d.st   = WK_CHECK;
                    end
                end
            end
            WK_CHECK: begin
                if ((r_q.lvl == LVL_W'(MAX_LEVELS)) || lvl_bad) begin
                    r_d.fault = 1'b1;
                    r_d.cause = CAUSE_BADCFG;
                    r_d.st    = WK_DONE;
                end else begin
                    r_d.addr = lvl_addr;
                    r_d.rem  = lvl_rem_next;
                    r_d.st   = WK_REQ;
                end
            end
            WK_DONE: begin
                r_d.st = WK_IDLE;
            end
            default: begin
                r_d.st = WK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.st != WK_IDLE);
    assign done         = (r_q.st == WK_DONE);
    assign fault        = r_q.fault;
    assign fault_cause  = r_q.cause;
    assign real_addr    = r_q.ra;
    assign page_size    = r_q.psize;
    assign leaf_entry   = r_q.leaf;
    assign leaf_addr    = r_q.leaf_addr;
    assign mem_rd_valid = (r_q.st == WK_REQ);
    assign mem_rd_addr  = r_q.addr;

endmodule

// File: rtl/rw_walker_chk.sv
module rw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        fault,
    input logic [1:0]  fault_cause,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [63:0] mem_rd_addr,
    input logic        mem_rsp_valid
);

    logic outst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
        end else if (mem_rd_valid && mem_rd_ready) begin
            outst_q <= 1'b1;
        end else if (mem_rsp_valid) begin
            outst_q <= 1'b0;
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R10
    single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !mem_rd_valid);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_valid);

    // R12
    cause_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> ($countones(fault_cause) == 1));

    // R12
    cause_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (fault_cause == 2'b00));

endmodule

bind radix_walker rw_walker_chk u_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .done          (done),
    .fault         (fault),
    .fault_cause   (fault_cause),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/test_radix_walker.sv
`timescale 1ns/1ps
module test_radix_walker;

    localparam int PID_W = 20;
    localparam int LPID_W = 12;
    localparam int MAXL = 4;
    localparam logic [63:0] PTB = 64'h0000_0000_0001_0000;
    localparam logic [63:0] BASE_MSK = 64'h00FF_FFFF_FFFF_FF00;
    localparam logic [63:0] RPN_MSK  = 64'h00FF_FFFF_FFFF_F000;
    localparam logic [63:0] VB = 64'h8000_0000_0000_0000;
    localparam logic [63:0] LB = 64'h4000_0000_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [63:0] ea = '0;
    logic [PID_W-1:0] pid = '0;
    logic [LPID_W-1:0] lpid = '0;
    logic hyp_mode = 1'b0;
    logic part_radix = 1'b0;
    logic [63:0] ptab_base = PTB;
    logic [4:0] ptab_size = '0;
    logic busy, done, fault;
    logic [1:0] fault_cause;
    logic [63:0] real_addr, leaf_entry, leaf_addr, mem_rd_addr;
    logic [6:0] page_size;
    logic mem_rd_valid;
    logic mem_rd_ready = 1'b0;
    logic mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    always #2.5 clk = ~clk;

    radix_walker #(.PID_W(PID_W), .LPID_W(LPID_W), .MAX_LEVELS(MAXL)) i_radix_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .pid(pid), .lpid(lpid),
        .hyp_mode(hyp_mode), .part_radix(part_radix), .ptab_base(ptab_base),
        .ptab_size(ptab_size), .busy(busy), .done(done), .fault(fault),
        .fault_cause(fault_cause), .real_addr(real_addr), .page_size(page_size),
        .leaf_entry(leaf_entry), .leaf_addr(leaf_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    logic [63:0] mem [logic [63:0]];
    int vectors = 0;
    int errors = 0;

    logic [63:0] exp_q [$];
    logic e_fault;
    logic [1:0] e_cause;
    logic [63:0] e_ra, e_leaf, e_la;
    int e_ps;

    function automatic logic [63:0] rdm(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // memory responder: irregular ready, 1 or 2 cycle response latency
    initial begin
        int cnt = 0;
        bit pend = 0;
        int dly = 0;
        logic [63:0] paddr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = rdm(paddr);
                    pend = 0;
                end else begin
                    dly--;
                end
            end
            mem_rd_ready = !pend && ((cnt % 3) != 2);
            cnt++;
            if (mem_rd_valid && mem_rd_ready) begin
                pend = 1;
                paddr = mem_rd_addr;
                dly = cnt % 2;
            end
        end
    end

    // behavioural reference: expected read addresses and result
    task automatic model(input logic [63:0] m_ea, input int m_pid, input int m_lpid,
                         input bit m_hyp, input bit m_radix, input int m_sz);
        logic [63:0] off, a, e, b;
        int n, r, d;
        exp_q.delete();
        e_fault = 0; e_cause = 0; e_ra = 0; e_ps = 0; e_leaf = 0; e_la = 0;
        if (!m_radix || (m_lpid == 0 && !m_hyp)) begin
            e_fault = 1; e_cause = 2'b10; return;
        end
        off = 64'(m_pid) * 16;
        if (off >= (64'd1 << (m_sz + 12))) begin
            e_fault = 1; e_cause = 2'b01; return;
        end
        a = PTB + off;
        exp_q.push_back(a);
        e = rdm(a);
        b = e & BASE_MSK;
        n = int'(e & 64'd31);
        r = int'((e >> 56) & 64'd63);
        d = 0;
        while (1) begin
            if (d == MAXL || n < 5 || n > r) begin
                e_fault = 1; e_cause = 2'b10; return;
            end
            r -= n;
            a = b + ((m_ea >> r) & ((64'd1 << n) - 1)) * 8;
            exp_q.push_back(a);
            e = rdm(a);
            if (!e[63]) begin
                e_fault = 1; e_cause = 2'b01; return;
            end
            if (e[62]) begin
                e_ra = ((e & RPN_MSK) & ~((64'd1 << r) - 1)) | (m_ea & ((64'd1 << r) - 1));
                e_ps = r; e_leaf = e; e_la = a;
                return;
            end
            b = e & BASE_MSK;
            n = int'(e & 64'd31);
            d++;
        end
    endtask

    // set up one chain of tables along the path of b_ea
    task automatic build(input int b_pid, input logic [63:0] b_ea, input int total,
                         input int nl[4], input int nlev, input logic [63:0] last);
        logic [63:0] b, nb, a, base0;
        int r, n;
        base0 = 64'h0100_0000 * 64'(b_pid + 1);
        mem[PTB + 64'(b_pid) * 16] = (64'(total) << 56) | base0 | 64'(nl[0]);
        r = total;
        b = base0;
        for (int l = 0; l < nlev; l++) begin
            n = nl[l];
            r -= n;
            a = b + ((b_ea >> r) & ((64'd1 << n) - 1)) * 8;
            if (l == nlev - 1) begin
                mem[a] = last;
            end else begin
                nb = b + 64'h0010_0000;
                mem[a] = VB | nb | 64'(nl[l + 1]);
                b = nb;
            end
        end
    endtask

    task automatic run(input string tag, input logic [63:0] t_ea, input int t_pid,
                       input int t_lpid, input bit t_hyp, input bit t_radix,
                       input int t_sz, input bit poke);
        int nrd = 0;
        int cyc = 0;
        bit got = 0;
        logic [63:0] held;
        model(t_ea, t_pid, t_lpid, t_hyp, t_radix, t_sz);
        @(negedge clk);
        ea = t_ea; pid = PID_W'(t_pid); lpid = LPID_W'(t_lpid);
        hyp_mode = t_hyp; part_radix = t_radix; ptab_size = 5'(t_sz);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!got && cyc < 3000) begin
            #1;
            if (poke && cyc == 2) begin
                start = 1'b1; ea = ~t_ea; pid = PID_W'(t_pid + 1);
            end
            if (poke && cyc == 3) start = 1'b0;
            if (!done) chk(busy == 1'b1, tag, "R11 busy during walk", 64'(busy), 64'd1);
            if (mem_rd_valid && mem_rd_ready) begin
                if (nrd < exp_q.size())
                    chk(mem_rd_addr == exp_q[nrd], tag, "R5 read address", mem_rd_addr, exp_q[nrd]);
                else
                    chk(1'b0, tag, "R10 extra read", mem_rd_addr, 64'd0);
                nrd++;
            end
            if (done) begin
                got = 1;
                chk(nrd == exp_q.size(), tag, "R10 read count", 64'(nrd), 64'(exp_q.size()));
                chk(fault == e_fault, tag, "R12 fault", 64'(fault), 64'(e_fault));
                chk(fault_cause == e_cause, tag, "R12 fault_cause", 64'(fault_cause), 64'(e_cause));
                chk(real_addr == e_ra, tag, "R7 real_addr", real_addr, e_ra);
                chk(page_size == 7'(e_ps), tag, "R7 page_size", 64'(page_size), 64'(e_ps));
                chk(leaf_entry == e_leaf, tag, "R7 leaf_entry", leaf_entry, e_leaf);
                chk(leaf_addr == e_la, tag, "R7 leaf_addr", leaf_addr, e_la);
            end
            cyc++;
            if (!got) @(negedge clk);
        end
        if (!got) begin
            chk(1'b0, tag, "watchdog: no done", 64'(cyc), 64'd0);
        end else begin
            held = real_addr;
            @(negedge clk);
            #1;
            chk(!done && !busy, tag, "R11 done one cycle", {62'd0, done, busy}, 64'd0);
            chk(real_addr == held, tag, "R11 result held", real_addr, held);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [63:0] ea_a, ea_b, ea_c, ea_d;
        ea_a = 64'h0003_9ABC_DEF1_2345;
        ea_b = 64'h0007_1234_5678_9ABC;
        ea_c = 64'h000C_0FED_CBA9_8765;
        ea_d = 64'h0001_5555_AAAA_3333;

        build(1, ea_a, 52, '{13, 9, 9, 9}, 4, VB | LB | 64'h0000_0012_3456_7000);
        build(2, ea_b, 52, '{13, 9, 9, 0}, 3, VB | LB | 64'h0000_0034_567F_F000);
        build(3, ea_c, 52, '{13, 0, 0, 0}, 1, VB | LB | 64'h00AB_CDEF_FFFF_F000);
        build(4, ea_d, 52, '{13, 9, 0, 0}, 2, 64'h0000_0000_0012_3000);
        build(5, ea_a, 52, '{4, 0, 0, 0}, 0, 64'd0);
        build(6, ea_b, 52, '{13, 3, 0, 0}, 1, VB | 64'h0700_0000 | 64'd3);
        build(7, ea_c, 52, '{5, 5, 5, 5}, 4, VB | 64'h0900_0000 | 64'd5);
        build(8, ea_d, 20, '{13, 9, 0, 0}, 1, VB | 64'h0A00_0000 | 64'd9);
        build(255, ea_a, 40, '{13, 0, 0, 0}, 1, VB | LB | 64'h0000_00FF_F000_0000);
        build(256, ea_b, 48, '{16, 0, 0, 0}, 1, VB | LB | 64'h0000_7700_0000_0000);

        repeat (4) @(negedge clk);
        #1;
        chk(!busy && !done && !mem_rd_valid, "R11", "reset state",
            {61'd0, busy, done, mem_rd_valid}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        run("R7 four-level small page", ea_a, 1, 3, 0, 1, 0, 0);
        run("R8 mid-level large page", ea_b, 2, 3, 0, 1, 0, 0);
        run("R3 leaf under root", ea_c, 3, 3, 0, 1, 0, 0);
        run("R6 invalid entry", ea_d, 4, 3, 0, 1, 0, 0);
        run("R4 narrow root index", ea_a, 5, 3, 0, 1, 0, 0);
        run("R4 narrow lower index", ea_b, 6, 3, 0, 1, 0, 0);
        run("R9 depth limit", ea_c, 7, 3, 0, 1, 0, 0);
        run("R4 index wider than remainder", ea_d, 8, 3, 0, 1, 0, 0);
        run("R2 last pid in table", ea_a, 255, 3, 0, 1, 0, 0);
        run("R2 pid past table", ea_a, 256, 3, 0, 1, 0, 0);
        run("R2 larger table code", ea_b, 256, 3, 0, 1, 1, 0);
        run("R1 radix flag clear", ea_a, 1, 3, 0, 0, 0, 0);
        run("R1 partition zero guest", ea_a, 1, 0, 0, 1, 0, 0);
        run("R1 partition zero hypervisor", ea_a, 1, 0, 1, 1, 0, 0);
        run("R11 start while busy", ea_a, 1, 3, 0, 1, 0, 1);
        run("R5 repeat after poke", ea_b, 2, 3, 1, 1, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule